// File: doc/BRIEF.md
# PCI Power-State Controller

This block keeps track of the power state of a PCI function. It combines software writes to a two-bit power-state field with the I/O-space, memory-space and bus-master enable bits of the command register. From these it produces registered qualifiers that tell the rest of the device whether it may claim I/O or memory target cycles, accept configuration cycles, or start transactions as a bus master.

The block has two separate full-power states: uninitialized and active. After reset, and whenever the function returns from D3hot, it sits in the uninitialized state. In that state it answers nothing and does not master the bus. It moves to the active state only once configuration software has turned on a command enable.

The controller also holds a wake status bit. An internal wake event sets this bit while the function is in a low-power state. The active-low PME output is driven low only while three things are true at once: the status bit is set, the PME enable is on, and the function is in D1 or D3hot.

Top module: `pci_pwr_state_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge show D0 uninitialized. That means `pstate_o`=00, `uninit_o`=1, `cfg_ok`=`io_ok`=`mem_ok`=`master_ok`=0, and `pme_n`=1. The wake status is also cleared.
- R2: In D0 uninitialized, `io_ok`, `mem_ok`, `master_ok` and `cfg_ok` are all 0.
- R3: In D0 uninitialized, the function moves to D0 active at the next edge if any of `io_en`, `mem_en` or `bm_en` is 1. If a power-state write to 01 or 11 arrives in the same cycle, the write takes precedence.
- R4: In D0 active, `cfg_ok` is 1. `io_ok`, `mem_ok` and `master_ok` each equal the value that `io_en`, `mem_en` and `bm_en` had at the previous edge. Clearing all enables does not leave D0 active.
- R5: The field code written on `ps_wdata` with `ps_wr` high is 00=D0, 01=D1, 11=D3hot, and `pstate_o` reports the same code. From either D0 state, writing 01 enters D1 and writing 11 enters D3hot. From D1, writing 11 enters D3hot. Writing the code of the current state changes nothing.
- R6: A write of the reserved code 10 changes no output, in any state. In D3hot, a write of 01 is also ignored.
- R7: In D1 and D3hot, `io_ok`, `mem_ok` and `master_ok` are 0 and `cfg_ok` is 1.
- R8: In D3hot, writing 00 enters D0 uninitialized, not D0 active. From there, R3 applies at the following edges.
- R9: In D1, writing 00 enters D0 active directly.
- R10: A `wake_evt` in D1 or D3hot sets the wake status. A `wake_evt` in either D0 state is ignored. `pme_clr` clears the status, but a set in the same cycle wins. `pme_n` goes low at the edge where the status is set (or already set), `pme_en` is 1 and the state is D1 or D3hot.
- R11: `pme_n` is 1 in both D0 states, even while the wake status is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_wr | input | 1 | Write strobe for the power-state field |
| ps_wdata | input | 2 | Power-state code being written |
| io_en | input | 1 | Command register I/O-space enable |
| mem_en | input | 1 | Command register memory-space enable |
| bm_en | input | 1 | Command register bus-master enable |
| pme_en | input | 1 | PME enable bit |
| pme_clr | input | 1 | Software clear of the wake status |
| wake_evt | input | 1 | Internal wake event |
| pstate_o | output | 2 | Current power-state code |
| uninit_o | output | 1 | High in D0 uninitialized |
| cfg_ok | output | 1 | Configuration cycles may be accepted |
| io_ok | output | 1 | I/O target cycles may be claimed |
| mem_ok | output | 1 | Memory target cycles may be claimed |
| master_ok | output | 1 | Bus mastering allowed |
| pme_n | output | 1 | Active-low PME wake request |

## Verification
Two pairs of functions can land on the same edge.

The first pair is setting and clearing the wake status. The bench drives `wake_evt` and `pme_clr` together while in D1 with `pme_en` on, and expects `pme_n` to stay low because the set wins.

The second pair is promotion out of D0 uninitialized and a power-state write. The bench raises a command enable in the same cycle as a write of 01 and expects D1 rather than D0 active.

A scoreboard model, written from the requirements, predicts every output after each edge.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int PS_W = 2;
  typedef logic [PS_W-1:0] ps_code_t;

  localparam ps_code_t PS_D0  = 2'b00;
  localparam ps_code_t PS_D1  = 2'b01;
  localparam ps_code_t PS_RSV = 2'b10;
  localparam ps_code_t PS_D3  = 2'b11;

  typedef enum logic [1:0] {
    ST_D0U = 2'd0,
    ST_D0A = 2'd1,
    ST_D1  = 2'd2,
    ST_D3  = 2'd3
  } pst_e;

  function automatic ps_code_t st_code(pst_e s);
    case (s)
      ST_D1:   return PS_D1;
      ST_D3:   return PS_D3;
      default: return PS_D0;
    endcase
  endfunction

  function automatic logic st_low(pst_e s);
    return (s == ST_D1) || (s == ST_D3);
  endfunction
endpackage

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
#(
  parameter bit PROMOTE_ANY = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ps_wr,
  input  ps_code_t ps_wdata,
  input  logic     io_en,
  input  logic     mem_en,
  input  logic     bm_en,
  output pst_e     st_q,
  output pst_e     st_d
);
  logic cfg_done;
  logic wr_d0, wr_d1, wr_d3;

  generate
    if (PROMOTE_ANY) begin : g_any
      assign cfg_done = io_en | mem_en | bm_en;
    end else begin : g_all
      assign cfg_done = io_en & mem_en & bm_en;
    end
  endgenerate

  assign wr_d0 = ps_wr && (ps_wdata == PS_D0);
  assign wr_d1 = ps_wr && (ps_wdata == PS_D1);
  assign wr_d3 = ps_wr && (ps_wdata == PS_D3);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_D0U: begin
        if (wr_d1)         st_d = ST_D1;
        else if (wr_d3)    st_d = ST_D3;
        else if (cfg_done) st_d = ST_D0A;
      end
      ST_D0A: begin
        if (wr_d1)      st_d = ST_D1;
        else if (wr_d3) st_d = ST_D3;
      end
      ST_D1: begin
        if (wr_d0)      st_d = ST_D0A;
        else if (wr_d3) st_d = ST_D3;
      end
      ST_D3: begin
        if (wr_d0) st_d = ST_D0U;
      end
      default: st_d = ST_D0U;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_D0U;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/pwr_gate_out.sv
module pwr_gate_out
  import pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pst_e     st_d,
  input  logic     io_en,
  input  logic     mem_en,
  input  logic     bm_en,
  output ps_code_t pstate_o,
  output logic     uninit_o,
  output logic     cfg_ok,
  output logic     io_ok,
  output logic     mem_ok,
  output logic     master_ok
);
  logic act_d;
  assign act_d = (st_d == ST_D0A);

  always_ff @(posedge clk) begin
    if (rst) begin
      pstate_o  <= PS_D0;
      uninit_o  <= 1'b1;
      cfg_ok    <= 1'b0;
      io_ok     <= 1'b0;
      mem_ok    <= 1'b0;
      master_ok <= 1'b0;
    end else begin
      pstate_o  <= st_code(st_d);
      uninit_o  <= (st_d == ST_D0U);
      cfg_ok    <= (st_d != ST_D0U);
      io_ok     <= act_d & io_en;
      mem_ok    <= act_d & mem_en;
      master_ok <= act_d & bm_en;
    end
  end
endmodule

// File: rtl/pwr_pme_ctrl.sv
module pwr_pme_ctrl
  import pwr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  pst_e st_q,
  input  pst_e st_d,
  input  logic wake_evt,
  input  logic pme_en,
  input  logic pme_clr,
  output logic pme_n
);
  logic sts_q, sts_d;

  always_comb begin
    if (wake_evt && st_low(st_q)) sts_d = 1'b1;
    else if (pme_clr)             sts_d = 1'b0;
    else                          sts_d = sts_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      pme_n <= 1'b1;
    end else begin
      sts_q <= sts_d;
      pme_n <= ~(sts_d & pme_en & st_low(st_d));
    end
  end
endmodule

// File: rtl/pci_pwr_state_ctrl.sv
module pci_pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter bit PROMOTE_ANY = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps_wr,
  input  logic [1:0] ps_wdata,
  input  logic       io_en,
  input  logic       mem_en,
  input  logic       bm_en,
  input  logic       pme_en,
  input  logic       pme_clr,
  input  logic       wake_evt,
  output logic [1:0] pstate_o,
  output logic       uninit_o,
  output logic       cfg_ok,
  output logic       io_ok,
  output logic       mem_ok,
  output logic       master_ok,
  output logic       pme_n
);
  pst_e st_q, st_d;

  pwr_state_fsm #(.PROMOTE_ANY(PROMOTE_ANY)) u_fsm (
    .clk(clk), .rst(rst), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
    .io_en(io_en), .mem_en(mem_en), .bm_en(bm_en),
    .st_q(st_q), .st_d(st_d)
  );

  pwr_gate_out u_gate (
    .clk(clk), .rst(rst), .st_d(st_d),
    .io_en(io_en), .mem_en(mem_en), .bm_en(bm_en),
    .pstate_o(pstate_o), .uninit_o(uninit_o), .cfg_ok(cfg_ok),
    .io_ok(io_ok), .mem_ok(mem_ok), .master_ok(master_ok)
  );

  pwr_pme_ctrl u_pme (
    .clk(clk), .rst(rst), .st_q(st_q), .st_d(st_d),
    .wake_evt(wake_evt), .pme_en(pme_en), .pme_clr(pme_clr),
    .pme_n(pme_n)
  );
endmodule

// File: rtl/pwr_ctrl_checker.sv
module pwr_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic       ps_wr,
  input logic [1:0] ps_wdata,
  input logic       io_en,
  input logic       mem_en,
  input logic       bm_en,
  input logic       pme_en,
  input logic       pme_clr,
  input logic       wake_evt,
  input logic [1:0] pstate_o,
  input logic       uninit_o,
  input logic       cfg_ok,
  input logic       io_ok,
  input logic       mem_ok,
  input logic       master_ok,
  input logic       pme_n
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (uninit_o && pstate_o == 2'b00 && pme_n && !cfg_ok));

  // R2
  uninit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    uninit_o |-> (!io_ok && !mem_ok && !master_ok && !cfg_ok));

  // R4
  active_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!uninit_o && pstate_o == 2'b00) |->
      (cfg_ok && io_ok == $past(io_en) && mem_ok == $past(mem_en) &&
       master_ok == $past(bm_en)));

  // R6
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ps_wr && ps_wdata == 2'b10) |=> $stable(pstate_o));

  // R7
  lowpower_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pstate_o != 2'b00) |-> (cfg_ok && !io_ok && !mem_ok && !master_ok));

  // R8
  d3_exit_uninit_chk: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 2'b11 && ps_wr && ps_wdata == 2'b00) |=> uninit_o);

  // R9
  d1_exit_active_chk: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 2'b01 && ps_wr && ps_wdata == 2'b00) |=>
      (!uninit_o && pstate_o == 2'b00));

  // R10
  wake_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (pstate_o != 2'b00 && wake_evt && pme_en && !ps_wr) |=> !pme_n);

  // R10
  pme_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pme_n && !pme_clr && pme_en && !ps_wr) |=> !pme_n);

  // R11
  no_pme_in_d0_chk: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 2'b00) |-> pme_n);
endmodule

bind pci_pwr_state_ctrl pwr_ctrl_checker chk (.*);

// File: tb/pci_pwr_state_ctrl_test.sv
module pci_pwr_state_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, ps_wr = 1'b0, io_en = 1'b0, mem_en = 1'b0, bm_en = 1'b0;
  logic pme_en = 1'b0, pme_clr = 1'b0, wake_evt = 1'b0;
  logic [1:0] ps_wdata = 2'b00;
  logic [1:0] pstate_o;
  logic uninit_o, cfg_ok, io_ok, mem_ok, master_ok, pme_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  string      q_tag[$];
  logic [7:0] q_exp[$];

  // model: 0 D0 uninit, 1 D0 active, 2 D1, 3 D3hot
  int m_st = 0;
  bit m_sts = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pci_pwr_state_ctrl uut (
    .clk(clk), .rst(rst), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
    .io_en(io_en), .mem_en(mem_en), .bm_en(bm_en),
    .pme_en(pme_en), .pme_clr(pme_clr), .wake_evt(wake_evt),
    .pstate_o(pstate_o), .uninit_o(uninit_o), .cfg_ok(cfg_ok),
    .io_ok(io_ok), .mem_ok(mem_ok), .master_ok(master_ok), .pme_n(pme_n)
  );

  task automatic step(input string tag, input bit r, input bit wr,
                      input logic [1:0] wd, input bit io, input bit mem,
                      input bit bm, input bit pen, input bit clr, input bit wk);
    int nst;
    bit nsts;
    logic [1:0] code;
    @(negedge clk);
    rst = r; ps_wr = wr; ps_wdata = wd; io_en = io; mem_en = mem;
    bm_en = bm; pme_en = pen; pme_clr = clr; wake_evt = wk;
    nst = m_st;
    if (r) begin
      nst = 0;
      nsts = 1'b0;
    end else begin
      case (m_st)
        0: if (wr && wd == 2'b01) nst = 2;
           else if (wr && wd == 2'b11) nst = 3;
           else if (io || mem || bm) nst = 1;
        1: if (wr && wd == 2'b01) nst = 2;
           else if (wr && wd == 2'b11) nst = 3;
        2: if (wr && wd == 2'b00) nst = 1;
           else if (wr && wd == 2'b11) nst = 3;
        default: if (wr && wd == 2'b00) nst = 0;
      endcase
      if (wk && m_st >= 2) nsts = 1'b1;
      else if (clr)        nsts = 1'b0;
      else                 nsts = m_sts;
    end
    code = (nst == 2) ? 2'b01 : (nst == 3) ? 2'b11 : 2'b00;
    q_tag.push_back(tag);
    q_exp.push_back({code, nst == 0, (nst == 1) && io, (nst == 1) && mem,
                     (nst == 1) && bm, nst != 0, !(nsts && pen && nst >= 2)});
    m_st = nst;
    m_sts = nsts;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q_exp.size() > 0) begin
        string t;
        logic [7:0] e, a;
        t = q_tag.pop_front();
        e = q_exp.pop_front();
        a = {pstate_o, uninit_o, io_ok, mem_ok, master_ok, cfg_ok, pme_n};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b (pstate,uninit,io,mem,bm,cfg,pme_n)",
                   t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD*200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    //   tag  rst wr wd  io mem bm pen clr wk
    step("R1", 1, 0, 2'b00, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 0, 2'b00, 1, 1, 1, 1, 0, 1);
    step("R2", 0, 0, 2'b00, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 1, 2'b10, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 2'b00, 0, 0, 0, 1, 0, 1);   // wake ignored in D0
    step("R3", 0, 0, 2'b00, 0, 1, 0, 1, 0, 0);    // mem only promotes
    step("R4", 0, 0, 2'b00, 1, 1, 1, 1, 0, 0);
    step("R4", 0, 0, 2'b00, 1, 0, 1, 1, 0, 0);
    step("R4", 0, 0, 2'b00, 0, 0, 0, 1, 0, 0);    // stays active
    step("R6", 0, 1, 2'b10, 1, 1, 1, 1, 0, 0);
    step("R5", 0, 1, 2'b00, 1, 1, 1, 1, 0, 0);    // same-state write
    step("R5", 0, 1, 2'b01, 1, 1, 1, 0, 0, 0);    // to D1
    step("R7", 0, 0, 2'b00, 1, 1, 1, 0, 0, 0);
    step("R10", 0, 0, 2'b00, 1, 1, 1, 0, 0, 1);   // wake, pme off
    step("R10", 0, 0, 2'b00, 1, 1, 1, 1, 0, 0);   // enable -> low
    step("R10", 0, 0, 2'b00, 1, 1, 1, 1, 1, 1);   // set beats clear
    step("R10", 0, 0, 2'b00, 1, 1, 1, 1, 1, 0);   // clear -> high
    step("R5", 0, 1, 2'b01, 1, 1, 1, 1, 0, 0);    // same-state write
    step("R5", 0, 1, 2'b11, 1, 1, 1, 1, 0, 0);    // D1 -> D3hot
    step("R6", 0, 1, 2'b01, 1, 1, 1, 1, 0, 0);    // ignored in D3hot
    step("R6", 0, 1, 2'b10, 1, 1, 1, 1, 0, 0);
    step("R10", 0, 0, 2'b00, 1, 1, 1, 1, 0, 1);   // wake in D3hot
    step("R8", 0, 1, 2'b00, 0, 0, 0, 1, 0, 0);    // D3 -> D0 uninit
    step("R11", 0, 0, 2'b00, 0, 0, 0, 1, 0, 0);   // status held, pme high
    step("R3", 0, 0, 2'b00, 0, 0, 1, 1, 0, 0);    // bm only promotes
    step("R5", 0, 1, 2'b01, 0, 0, 1, 1, 0, 0);    // D1 again: pme low
    step("R9", 0, 1, 2'b00, 1, 1, 1, 1, 0, 0);    // D1 -> D0 active
    step("R11", 0, 0, 2'b00, 1, 1, 1, 1, 0, 1);
    step("R10", 0, 0, 2'b00, 1, 1, 1, 1, 1, 0);   // clear in D0
    step("R5", 0, 1, 2'b11, 1, 1, 1, 1, 0, 0);    // D0 -> D3hot, no pme
    step("R8", 0, 1, 2'b00, 1, 0, 0, 1, 0, 0);    // uninit first
    step("R3", 0, 0, 2'b00, 1, 0, 0, 1, 0, 0);    // then promotes
    step("R5", 0, 1, 2'b11, 1, 0, 0, 1, 0, 0);
    step("R8", 0, 1, 2'b00, 0, 0, 0, 1, 0, 0);
    step("R3", 0, 1, 2'b01, 1, 1, 1, 1, 0, 0);    // write beats promotion
    step("R1", 1, 0, 2'b00, 1, 1, 1, 1, 0, 0);    // reset from D1
    step("R2", 0, 1, 2'b10, 0, 0, 0, 1, 0, 1);
    step("R5", 0, 1, 2'b11, 0, 0, 0, 1, 0, 0);    // uninit -> D3hot
    step("R7", 0, 0, 2'b00, 1, 1, 1, 1, 0, 0);
    @(negedge clk);
    rst = 1'b0; ps_wr = 1'b0;
    repeat (3) @(posedge clk);
    #(PERIOD/2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule